// File: doc/BRIEF.md
# AES Column Mixer with Fused Round-Key XOR

This block transforms one 32-bit AES state column. The column is the four bytes of the state in one column. A single mode pin selects the direction. In encrypt mode the column goes through the forward column mix, and a 32-bit round-key word is XORed into the result inside the same logic. In decrypt mode the column goes through the inverse column mix, and the key word has no effect. In that direction the key addition happens elsewhere in the round, before this unit.

Both directions share one network of doubling (xtime) stages. The inverse mix is built as a light pre-conditioning step followed by the forward mix. The pre-conditioning adds four-times multiples of the column's alternate-byte sums. The forward path is shorter than the inverse path, so the encrypt key XOR fits into the forward XOR tree. No separate key stage and no output selector are needed.

The unit is purely combinational. It has no clock or reset, and its output follows its inputs within the same cycle. It sits between the substitution/row-shift logic and the round register of a pipelined round. Because it has no storage, it has no valid/ready handshake: the enclosing pipeline stage owns the flow control and any back-pressure.

Top module: `col_mix_unit`

## Requirements
- R1: Byte r of a column sits at bits [31-8r:24-8r] (byte 0 is the most significant byte), and the same ordering applies to the key word and to the output.
- R2: With `enc_mode` = 1, output byte r equals 2·a[r] ^ 3·a[r+1] ^ a[r+2] ^ a[r+3] ^ k[r], with indices taken modulo 4. Products are in GF(2^8) with reduction polynomial 0x11B, and k is the key word.
- R3: With `enc_mode` = 0, output byte r equals 14·a[r] ^ 11·a[r+1] ^ 13·a[r+2] ^ 9·a[r+3], with indices taken modulo 4.
- R4: With `enc_mode` = 0, the value of `key_word` has no effect on `col_out`.
- R5: Doubling reduces correctly: a byte whose top bit is set doubles to (byte<<1)^0x1B. For example, input column 80 00 00 00 in encrypt mode with a zero key gives 1b 80 80 9b.
- R6: The column db 13 53 45 with a zero key gives 8e 4d a1 bc in encrypt mode, and decrypting 8e 4d a1 bc gives back db 13 53 45.
- R7: For any column c, decrypting the encrypt-mode output of c taken with a zero key returns c.
- R8: In encrypt mode, changing the key word by a value d changes the output by exactly d. An all-zero column gives the key word itself.
- R9: A column whose four bytes are equal is returned unchanged by the inverse mix, and is returned XORed with the key by the encrypt path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_mode | input | 1 | 1 selects forward mix plus key XOR, 0 selects inverse mix |
| col_in | input | 32 | State column, byte 0 in the top byte |
| key_word | input | 32 | Round-key word, used in encrypt mode only |
| col_out | output | 32 | Mixed column |

## Verification
The checker assumes that the inputs carry known values whenever it evaluates. It skips any evaluation where a pin is unknown. It also assumes that the mode pin is held steady while a column is presented. The bench only ever applies both mode and data as fully defined values, changes them together on the clock's rising edge, and reads the result half a period later. The inputs are therefore settled before any comparison is made.

// File: rtl/colmix_pkg.sv
package colmix_pkg;
  localparam int BYTE_W    = 8;
  localparam int COL_BYTES = 4;
  localparam int COL_W     = BYTE_W * COL_BYTES;
  localparam int HALF      = COL_BYTES / 2;
  localparam logic [BYTE_W-1:0] RED_LOW = 8'h1B;

  typedef logic [BYTE_W-1:0] gf_byte_t;
  typedef gf_byte_t [COL_BYTES-1:0] col_arr_t;

  // byte r of the column lives in the top-down r-th byte lane
  function automatic col_arr_t unpack_col(input logic [COL_W-1:0] w);
    col_arr_t c;
    for (int r = 0; r < COL_BYTES; r++)
      c[r] = w[COL_W-1-BYTE_W*r -: BYTE_W];
    return c;
  endfunction

  function automatic logic [COL_W-1:0] pack_col(input col_arr_t c);
    logic [COL_W-1:0] w;
    for (int r = 0; r < COL_BYTES; r++)
      w[COL_W-1-BYTE_W*r -: BYTE_W] = c[r];
    return w;
  endfunction
endpackage

// File: rtl/cm_dbl_stage.sv
// Cascaded doubling: times-two and times-four from one byte.
module cm_dbl_stage
  import colmix_pkg::*;
(
  input  gf_byte_t din,
  output gf_byte_t x2,
  output gf_byte_t x4
);
  gf_byte_t red1;
  gf_byte_t red2;

  always_comb begin
    red1 = din[BYTE_W-1] ? RED_LOW : '0;
    x2   = {din[BYTE_W-2:0], 1'b0} ^ red1;
    red2 = x2[BYTE_W-1] ? RED_LOW : '0;
    x4   = {x2[BYTE_W-2:0], 1'b0} ^ red2;
  end
endmodule

// File: rtl/cm_inv_prep.sv
// Conditions a column so that a following forward mix yields the inverse mix.
module cm_inv_prep
  import colmix_pkg::*;
(
  input  logic     active,
  input  col_arr_t col_i,
  output col_arr_t col_o
);
  gf_byte_t pair_sum [HALF];
  gf_byte_t pair_x2  [HALF];
  gf_byte_t pair_x4  [HALF];

  for (genvar p = 0; p < HALF; p++) begin : g_pair
    assign pair_sum[p] = col_i[p] ^ col_i[p+HALF];

    cm_dbl_stage u_dbl (
      .din (pair_sum[p]),
      .x2  (pair_x2[p]),
      .x4  (pair_x4[p])
    );
  end

  for (genvar r = 0; r < COL_BYTES; r++) begin : g_lane
    assign col_o[r] = col_i[r] ^ (active ? pair_x4[r % HALF] : '0);
  end
endmodule

// File: rtl/cm_fwd_mix.sv
// Forward column mix with the key byte folded into the XOR tree.
module cm_fwd_mix
  import colmix_pkg::*;
(
  input  col_arr_t col_i,
  input  col_arr_t key_i,
  output col_arr_t col_o
);
  for (genvar r = 0; r < COL_BYTES; r++) begin : g_row
    localparam int N1 = (r + 1) % COL_BYTES;
    localparam int N2 = (r + 2) % COL_BYTES;
    localparam int N3 = (r + 3) % COL_BYTES;

    gf_byte_t adj_sum;
    gf_byte_t adj_x2;
    gf_byte_t adj_x4_unused;
    gf_byte_t rest;

    assign adj_sum = col_i[r] ^ col_i[N1];

    cm_dbl_stage u_dbl (
      .din (adj_sum),
      .x2  (adj_x2),
      .x4  (adj_x4_unused)
    );

    // key joins the branch that runs parallel to the doubling
    assign rest     = (col_i[N1] ^ col_i[N2]) ^ (col_i[N3] ^ key_i[r]);
    assign col_o[r] = adj_x2 ^ rest;
  end
endmodule

// File: rtl/col_mix_unit.sv
module col_mix_unit
  import colmix_pkg::*;
(
  input  logic             enc_mode,
  input  logic [COL_W-1:0] col_in,
  input  logic [COL_W-1:0] key_word,
  output logic [COL_W-1:0] col_out
);
  col_arr_t col_a;
  col_arr_t col_pre;
  col_arr_t key_m;
  col_arr_t mixed;

  assign col_a = unpack_col(col_in);
  assign key_m = unpack_col(key_word & {COL_W{enc_mode}});

  cm_inv_prep u_prep (
    .active (~enc_mode),
    .col_i  (col_a),
    .col_o  (col_pre)
  );

  cm_fwd_mix u_mix (
    .col_i (col_pre),
    .key_i (key_m),
    .col_o (mixed)
  );

  assign col_out = pack_col(mixed);
endmodule

// File: rtl/col_mix_unit_chk.sv
module col_mix_unit_chk
  import colmix_pkg::*;
(
  input logic             enc_mode,
  input logic [COL_W-1:0] col_in,
  input logic [COL_W-1:0] key_word,
  input logic [COL_W-1:0] col_out,
  input col_arr_t         col_pre
);
  function automatic gf_byte_t fold(input logic [COL_W-1:0] w);
    gf_byte_t f = '0;
    for (int r = 0; r < COL_BYTES; r++) f ^= w[BYTE_W*r +: BYTE_W];
    return f;
  endfunction

  logic known;
  logic uniform;
  assign known   = !$isunknown({enc_mode, col_in, key_word, col_out});
  assign uniform = (col_in == {COL_BYTES{col_in[BYTE_W-1:0]}});

  always_comb begin
    if (known) begin
      // both coefficient sets sum to one, so the byte-XOR of a column is kept
      if (enc_mode)
        assert_fwd_parity_R2: assert (fold(col_out ^ key_word) == fold(col_in));
      else
        assert_inv_parity_R3: assert (fold(col_out) == fold(col_in));
      // conditioning adds the same term to partner bytes
      if (!enc_mode)
        assert_prep_pairs_R3: assert (((col_pre[0] ^ col_pre[2]) == (col_in[31:24] ^ col_in[15:8]))
                                   && ((col_pre[1] ^ col_pre[3]) == (col_in[23:16] ^ col_in[7:0])));
      if (enc_mode && col_in == '0)
        assert_zero_col_key_R8: assert (col_out == key_word);
      if (uniform)
        assert_uniform_fixed_R9: assert (col_out == (col_in ^ (enc_mode ? key_word : '0)));
    end
  end
endmodule

bind col_mix_unit col_mix_unit_chk i_chk (
  .enc_mode (enc_mode),
  .col_in   (col_in),
  .key_word (key_word),
  .col_out  (col_out),
  .col_pre  (col_pre)
);

// File: tb/test_col_mix_unit.sv
module test_col_mix_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        enc_mode;
  logic [31:0] col_in;
  logic [31:0] key_word;
  logic [31:0] col_out;
  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #(CLK_PERIOD/2) clk = ~clk;

  col_mix_unit i_col_mix_unit (
    .enc_mode (enc_mode),
    .col_in   (col_in),
    .key_word (key_word),
    .col_out  (col_out)
  );

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [31:0] ref_mix(input logic [31:0] c, input logic inv, input logic [31:0] k);
    logic [7:0] a [4];
    logic [7:0] co [4];
    logic [31:0] o;
    co = inv ? '{8'h0e, 8'h0b, 8'h0d, 8'h09} : '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int r = 0; r < 4; r++) a[r] = c[31-8*r -: 8];
    for (int r = 0; r < 4; r++) begin
      logic [7:0] s = '0;
      for (int j = 0; j < 4; j++) s ^= gmul(a[(r+j)%4], co[j]);
      o[31-8*r -: 8] = s ^ (inv ? 8'h00 : k[31-8*r -: 8]);
    end
    return o;
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  task automatic apply(input logic m, input logic [31:0] c, input logic [31:0] k);
    @(posedge clk);
    enc_mode = m; col_in = c; key_word = k;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic t_idle;
    apply(1'b1, 32'h0, 32'h0);
    check("R8 zero column zero key", col_out, 32'h0);
    apply(1'b0, 32'h0, 32'h0);
    check("R3 zero column decrypt", col_out, 32'h0);
  endtask

  task automatic t_known_vector;
    apply(1'b1, 32'hdb135345, 32'h0);
    check("R6 forward known", col_out, 32'h8e4da1bc);
    apply(1'b0, 32'h8e4da1bc, 32'h0);
    check("R6 inverse known", col_out, 32'hdb135345);
    apply(1'b1, 32'hf20a225c, 32'h0);
    check("R2 forward second vector", col_out, 32'h9fdc589d);
  endtask

  task automatic t_byte_order;
    apply(1'b1, 32'h01000000, 32'h0);
    check("R1 single top byte", col_out, 32'h02010103);
    apply(1'b1, 32'h00000001, 32'h0);
    check("R1 single bottom byte", col_out, 32'h01010302);
  endtask

  task automatic t_reduction;
    apply(1'b1, 32'h80000000, 32'h0);
    check("R5 top bit reduction", col_out, 32'h1b80809b);
    apply(1'b0, 32'h80000000, 32'h0);
    check("R5 inverse reduction", col_out, ref_mix(32'h80000000, 1'b1, 32'h0));
  endtask

  task automatic t_key_fusion;
    apply(1'b1, 32'h0, 32'hcafe1234);
    check("R8 zero column gives key", col_out, 32'hcafe1234);
    for (int i = 0; i < 20; i++) begin
      logic [31:0] c, k, base;
      seed = next_rand(seed); c = seed;
      seed = next_rand(seed); k = seed;
      apply(1'b1, c, 32'h0);
      base = col_out;
      apply(1'b1, c, k);
      check("R8 key delta", col_out, base ^ k);
      check("R2 forward with key", col_out, ref_mix(c, 1'b0, k));
    end
  endtask

  task automatic t_key_ignored;
    for (int i = 0; i < 20; i++) begin
      logic [31:0] c, k;
      seed = next_rand(seed); c = seed;
      seed = next_rand(seed); k = seed;
      apply(1'b0, c, k);
      check("R4 key ignored in decrypt", col_out, ref_mix(c, 1'b1, 32'h0));
      check("R3 inverse reference", col_out, ref_mix(c, 1'b1, 32'h0));
    end
  endtask

  task automatic t_round_trip;
    for (int i = 0; i < 30; i++) begin
      logic [31:0] c, f;
      seed = next_rand(seed); c = seed;
      apply(1'b1, c, 32'h0);
      f = col_out;
      apply(1'b0, f, 32'hffffffff);
      check("R7 round trip", col_out, c);
    end
  endtask

  task automatic t_uniform;
    apply(1'b0, 32'hc6c6c6c6, 32'h12345678);
    check("R9 uniform inverse", col_out, 32'hc6c6c6c6);
    apply(1'b1, 32'h5a5a5a5a, 32'h0f0f0000);
    check("R9 uniform forward keyed", col_out, 32'h5a5a5a5a ^ 32'h0f0f0000);
  endtask

  initial begin
    enc_mode = 1'b0; col_in = '0; key_word = '0;
    t_idle();
    t_known_vector();
    t_byte_order();
    t_reduction();
    t_key_fusion();
    t_key_ignored();
    t_round_trip();
    t_uniform();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule